// File: doc/BRIEF.md
# Scan Chunk Decimator with Stop Count

This block sits between the read side of a sample FIFO and a downstream consumer. The converter upstream runs continuously at a fixed per-channel rate. To obtain a slower scan rate, the incoming stream is cut into chunks of `chans × (1 + skip)` samples. Only the leading `chans` samples of each chunk, which form one complete scan, are passed on. The following `chans × skip` samples are consumed and thrown away. Software derives `skip` as `scan_period / (convert_period × chans) − 1`, with the scan period chosen as a whole multiple of `chans × convert_period`.

A pulse on `start` captures the configuration, clears the chunk position and loads the stop counter. In counted mode the counter holds `scans × chans × (1 + skip)`. It decrements on every sample consumed, whether that sample is forwarded or discarded. When it reaches zero, `done` is raised and no further samples are accepted. In continuous mode the block runs until the next `start`.

Both data interfaces use valid/ready. A sample transfers on a clock edge where valid and ready are both high. A sample that will be forwarded is accepted only when the consumer is ready, so back-pressure passes straight through to the FIFO. A sample that will be discarded is accepted whenever it is valid, whatever the state of `out_ready`. `in_ready` and `out_valid` are both low in the cycle where `start` is high.

Top module: `scan_chunk_decimator`

## Requirements
- R1: After reset, `done`, `out_valid` and `in_ready` are all 0.
- R2: A captured channel count of 0 behaves exactly like a channel count of 1.
- R3: Counting accepted samples from 0 after `start`, a sample at position p within its chunk (p = count mod chans×(1+skip)) is forwarded when p < chans and discarded otherwise. A forwarded sample appears on `out_data` unchanged.
- R4: With skip = 0, every accepted sample is forwarded.
- R5: While a sample due for forwarding is presented and `out_ready` is 0, `in_ready` is 0. The chunk position does not advance, and no sample is lost.
- R6: A sample due for discarding gives `out_valid` = 0 and `in_ready` = 1, independent of `out_ready`.
- R7: In counted mode (`cfg_continuous` = 0), exactly scans×chans×(1+skip) samples are accepted. `done` is 1 from the cycle after the last accepted sample, and from then on `in_ready` and `out_valid` stay 0.
- R8: In continuous mode (`cfg_continuous` = 1), `done` never rises and samples keep flowing.
- R9: `start` clears `done`, restarts the chunk position at 0 and reloads the stop counter, including while a run is in progress.
- R10: In counted mode with `cfg_scans` = 0, `done` is 1 in the cycle after `start`, and no sample is accepted.
- R11: Before the first `start`, `in_ready` and `out_valid` are 0.
- R12: Configuration inputs are captured only when `start` is high. Changing them during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_chans | input | CH_W | Channels per scan (0 treated as 1) |
| cfg_skip | input | SKIP_W | Scans discarded after each kept scan |
| cfg_scans | input | SCAN_W | Number of kept scans in counted mode |
| cfg_continuous | input | 1 | 1 = run until the next start |
| start | input | 1 | Capture configuration and begin a run |
| in_valid | input | 1 | Input sample valid |
| in_data | input | DATA_W | Input sample |
| in_ready | output | 1 | Block accepts the input sample |
| out_valid | output | 1 | Output sample valid |
| out_data | output | DATA_W | Output sample |
| out_ready | input | 1 | Consumer accepts the output sample |
| done | output | 1 | Counted run has finished |

## Verification
The hardest case to reach from the ports is a consumer stall that lands on each position of the chunk: on the first lane, on the last kept lane just before the discard window, and on the final sample of a counted run, where the stop counter is at one. The bench sweeps every small combination of channel count, skip factor and scan count. It runs each combination twice: once with `out_ready` always high, and once with `out_ready` dropping every third cycle, so that stalls fall on every position. The bench keeps its own running sample count and computes the expected keep or discard decision arithmetically from that count. A continuous run that is cut short by a fresh `start` in the middle of a discard window shows whether the position is really cleared.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } run_state_t;
endpackage

// File: rtl/sdec_pos_ctr.sv
module sdec_pos_ctr #(
  parameter int CH_W   = 5,
  parameter int SKIP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [CH_W-1:0]   chans,
  input  logic [SKIP_W-1:0] skip,
  output logic              keep
);
  logic [CH_W-1:0]   lane_q;
  logic [SKIP_W-1:0] rep_q;
  logic              last_lane;

  assign last_lane = (lane_q == chans - CH_W'(1));
  assign keep      = (rep_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      lane_q <= '0;
      rep_q  <= '0;
    end else if (step) begin
      if (last_lane) begin
        lane_q <= '0;
        rep_q  <= (rep_q == skip) ? '0 : rep_q + SKIP_W'(1);
      end else begin
        lane_q <= lane_q + CH_W'(1);
      end
    end
  end

  // R3
  lane_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_q < chans) && (rep_q <= skip));

  // R9
  clear_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (lane_q == '0) && keep);
endmodule

// File: rtl/sdec_stop_ctr.sv
module sdec_stop_ctr
  import sdec_pkg::*;
#(
  parameter int CNT_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             cont_in,
  input  logic             step,
  output logic             running,
  output logic             done
);
  run_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cont_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cont_q  <= 1'b0;
    end else if (load) begin
      cont_q  <= cont_in;
      cnt_q   <= load_val;
      state_q <= (!cont_in && load_val == '0) ? ST_DONE : ST_RUN;
    end else if (step && state_q == ST_RUN && !cont_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) state_q <= ST_DONE;
    end
  end

  assign running = (state_q == ST_RUN);
  assign done    = (state_q == ST_DONE);

  // R7
  no_accept_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !step);

  // R7
  last_sample_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && running && !cont_q && cnt_q == CNT_W'(1)) |=> done);

  // R8
  continuous_never_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cont_q |-> !done);
endmodule

// File: rtl/sdec_gate.sv
module sdec_gate (
  input  logic running,
  input  logic start,
  input  logic keep,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic accept
);
  logic live;

  assign live      = running && !start;
  assign in_ready  = live && (keep ? out_ready : 1'b1);
  assign out_valid = live && in_valid && keep;
  assign accept    = in_valid && in_ready;
endmodule

// File: rtl/scan_chunk_decimator.sv
module scan_chunk_decimator #(
  parameter int DATA_W = 16,
  parameter int CH_W   = 5,
  parameter int SKIP_W = 8,
  parameter int SCAN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_W-1:0]   cfg_chans,
  input  logic [SKIP_W-1:0] cfg_skip,
  input  logic [SCAN_W-1:0] cfg_scans,
  input  logic              cfg_continuous,
  input  logic              start,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              done
);
  localparam int CNT_W = SCAN_W + CH_W + SKIP_W + 1;

  logic [CH_W-1:0]   chans_eff;
  logic [CH_W-1:0]   chans_q;
  logic [SKIP_W-1:0] skip_q;
  logic [CNT_W-1:0]  load_val;
  logic              keep;
  logic              running;
  logic              accept;

  assign chans_eff = (cfg_chans == '0) ? CH_W'(1) : cfg_chans;
  assign load_val  = CNT_W'(cfg_scans) * CNT_W'(chans_eff)
                   * (CNT_W'(cfg_skip) + CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chans_q <= CH_W'(1);
      skip_q  <= '0;
    end else if (start) begin
      chans_q <= chans_eff;
      skip_q  <= cfg_skip;
    end
  end

  sdec_pos_ctr #(.CH_W(CH_W), .SKIP_W(SKIP_W)) u_pos (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start),
    .step  (accept),
    .chans (chans_q),
    .skip  (skip_q),
    .keep  (keep)
  );

  sdec_stop_ctr #(.CNT_W(CNT_W)) u_stop (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (load_val),
    .cont_in  (cfg_continuous),
    .step     (accept),
    .running  (running),
    .done     (done)
  );

  sdec_gate u_gate (
    .running   (running),
    .start     (start),
    .keep      (keep),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .accept    (accept)
  );

  assign out_data = in_data;

  // R5
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  done_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !in_ready));
endmodule

// File: tb/tb_scan_chunk_decimator.sv
`timescale 1ns/1ps
module tb_scan_chunk_decimator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_chans = '0;
  logic [7:0]  cfg_skip = '0;
  logic [15:0] cfg_scans = '0;
  logic        cfg_continuous = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_ready = 1'b1;
  logic        done;

  int tests = 0;
  int fails = 0;
  int seq   = 100;

  always #4 clk = ~clk;

  scan_chunk_decimator dut (
    .clk(clk), .rst_n(rst_n), .cfg_chans(cfg_chans), .cfg_skip(cfg_skip),
    .cfg_scans(cfg_scans), .cfg_continuous(cfg_continuous), .start(start),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .done(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input int ch, input int skp, input int sc,
                          input bit cont, input int mode, input int limit);
    int ch_eff, chunk, total, n, k, cyc;
    bit ek, acc;
    string tagk;
    ch_eff = (ch == 0) ? 1 : ch;
    chunk  = ch_eff * (skp + 1);
    total  = sc * chunk;
    n      = cont ? limit : total;
    tagk   = (ch == 0) ? "R2" : ((skp == 0) ? "R4" : "R3");
    @(negedge clk);
    cfg_chans = 5'(ch); cfg_skip = 8'(skp); cfg_scans = 16'(sc);
    cfg_continuous = cont; start = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R12: scramble configuration during the run
    cfg_chans = 5'(ch) ^ 5'h1B; cfg_skip = 8'(skp) ^ 8'h05;
    cfg_scans = 16'(sc) + 16'd3; cfg_continuous = ~cont;
    if (!cont && total == 0) begin
      in_valid = 1'b1;
      #1;
      chk(done == 1'b1, "R10 done", done, 1);
      chk(in_ready == 1'b0, "R10 in_ready", in_ready, 0);
      in_valid = 1'b0;
      return;
    end
    #1;
    chk(done == 1'b0, "R9 done cleared", done, 0);
    k = 0; cyc = 0;
    while (k < n) begin
      in_valid  = 1'b1;
      in_data   = 16'(seq);
      out_ready = (mode == 0) || (cyc % 3 != 0);
      #1;
      ek = (k % chunk) < ch_eff;
      if (ek) begin
        chk(out_valid == 1'b1, {tagk, " keep R12"}, out_valid, 1);
        if (out_valid) chk(out_data == 16'(seq), "R3 data", out_data, seq);
        chk(in_ready == out_ready, "R5 backpressure", in_ready, out_ready);
      end else begin
        chk(out_valid == 1'b0, "R6 drop valid", out_valid, 0);
        chk(in_ready == 1'b1, "R6 drop ready", in_ready, 1);
      end
      acc = in_valid && in_ready;
      @(negedge clk);
      if (acc) begin k++; seq++; end
      cyc++;
    end
    in_valid = 1'b1;
    #1;
    if (!cont) begin
      chk(done == 1'b1, "R7 done", done, 1);
      chk(in_ready == 1'b0, "R7 in_ready", in_ready, 0);
      chk(out_valid == 1'b0, "R7 out_valid", out_valid, 0);
    end else begin
      chk(done == 1'b0, "R8 done", done, 0);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog R7 actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    in_valid = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R11 in_ready", in_ready, 0);
    chk(out_valid == 1'b0, "R11 out_valid", out_valid, 0);
    in_valid = 1'b0;

    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 4; c++)
        for (int s = 0; s < 3; s++)
          for (int n = 0; n < 3; n++)
            run_case(c, s, n, 1'b0, m, 0);

    for (int c = 1; c < 4; c++)
      for (int s = 0; s < 3; s++)
        run_case(c, s, 0, 1'b1, 1, 2 * c * (s + 1) + 1);

    // R9: restart in the middle of a discard window, then a counted run
    run_case(2, 1, 0, 1'b1, 0, 3);
    run_case(2, 1, 2, 1'b0, 1, 0);
    run_case(3, 2, 0, 1'b1, 1, 7);
    run_case(3, 2, 1, 1'b0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule